// File: doc/BRIEF.md
# Doubleword Byte Gating Buffer

This block sits between a storage port that moves 64-bit doublewords and a device port that moves one byte at a time. It holds one doubleword in eight byte lanes. It keeps a lane pointer that selects the active lane and a remaining-count of bytes still to move. For an outbound transfer, it asks storage for a doubleword and then hands one byte to the device on each device request. Once the last lane of the buffer has gone out, it asks storage for the next doubleword. For an inbound transfer, it writes each device byte into the lane under the pointer. When the final lane is filled, or when the count runs out, it offers the doubleword to storage together with a mask of the lanes written since the previous store.

The first lane is taken from the low address bits supplied at start. A backward transfer loads the one's complement of those bits and then walks the lanes downward. The buffer is never cleared between doublewords, so lanes that were not rewritten keep their earlier contents in the stored data. The storage and device sides use only request/acknowledge handshakes. The block does not arbitrate for storage, check protection keys or drive the device tag protocol.

Top module: `dwbg_byte_gate`

## Requirements
- R1: After reset, fetch_req, store_req, dev_rdy and count_zero are low, remaining is zero and every buffer lane holds zero.
- R2: Lane k of the buffer is data bits [63-8k : 56-8k], so lane 0 is the most significant byte. On a forward start the pointer loads start_lane and then increments by one for each byte moved, wrapping from lane 7 to lane 0.
- R3: On a backward start (start_bwd=1) the pointer loads the one's complement of start_lane and then decrements by one for each byte moved, wrapping from lane 0 to lane 7.
- R4: For outbound transfers (start_dir=0), fetch_req is raised after a start with a nonzero count and is held until fetch_ack. Each accepted device request (dev_req and dev_rdy high together) presents on dev_rbyte the byte in the lane under the pointer. A new fetch is requested only after the byte in the edge lane (lane 7 forward, lane 0 backward) has been taken and bytes remain.
- R5: While a fetch is outstanding, dev_rdy stays low, so device requests are held off.
- R6: For inbound transfers (start_dir=1), each accepted byte is written into the lane under the pointer. After the byte in the edge lane is written, store_req rises with the whole buffer on store_data, and store_mask bit k set for each lane k written since the last store.
- R7: The buffer is never cleared. Lanes not written since the last fetch or store keep their previous bytes and appear unchanged in store_data.
- R8: remaining loads start_count on a start and decrements by one for each byte moved. When it reaches zero, count_zero rises, dev_rdy drops and no further fetch is requested.
- R9: When the count reaches zero part way through an inbound doubleword, the partial doubleword is stored, and store_mask marks only the lanes written.
- R10: store_req, store_data and store_mask stay stable until store_ack, and dev_rdy stays low while a store is pending.
- R11: A start pulse is ignored while a transfer is active or a store is pending. remaining, count_zero and the transfer in progress are left unchanged.
- R12: A start with a zero count raises count_zero at once and requests neither fetch nor store, and dev_rdy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse that loads the transfer parameters |
| start_dir | input | 1 | 0 = outbound (storage to device), 1 = inbound |
| start_bwd | input | 1 | Backward lane order |
| start_lane | input | 3 | Low address bits that select the first lane |
| start_count | input | 16 | Number of bytes to move |
| fetch_req | output | 1 | Request for a doubleword from storage |
| fetch_ack | input | 1 | Storage supplies fetch_data this cycle |
| fetch_data | input | 64 | Doubleword from storage |
| store_req | output | 1 | Request to write a doubleword to storage |
| store_ack | input | 1 | Storage accepts the store this cycle |
| store_data | output | 64 | Doubleword to store |
| store_mask | output | 8 | Bit k set when lane k holds a new byte |
| dev_req | input | 1 | Device byte request |
| dev_rdy | output | 1 | Block can take or give a byte this cycle |
| dev_wbyte | input | 8 | Inbound byte from the device |
| dev_rbyte | output | 8 | Outbound byte to the device |
| count_zero | output | 1 | Remaining count has reached zero |
| remaining | output | 16 | Bytes still to move |

## Verification
The assertions assume that storage behaves as a well-formed responder. It raises fetch_ack and store_ack only while the matching request is high, and it never acknowledges both a fetch and a store for the same transfer. They also assume that a start arrives only as a single-cycle pulse. The bench keeps to these assumptions by building its storage responders to wait a programmed latency after seeing a request and then acknowledge for exactly one cycle. Its device driver holds dev_req until dev_rdy is seen, and it issues each start for one cycle. The one deliberate start during a live transfer is there to exercise the rule that such a start is ignored.

// File: rtl/dwbg_pkg.sv
package dwbg_pkg;

   // Transfer direction as seen from storage
   typedef enum logic {
      XFER_OUT = 1'b0,   // storage -> device
      XFER_IN  = 1'b1    // device -> storage
   } xfer_dir_e;

endpackage

// File: rtl/dwbg_lane_ptr.sv
module dwbg_lane_ptr #(
   parameter int LANES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [$clog2(LANES)-1:0] addr_lo,
   input  logic                     backward,
   input  logic                     step,
   output logic [$clog2(LANES)-1:0] ptr,
   output logic                     at_edge
);
   localparam int PW = $clog2(LANES);
   localparam logic [PW-1:0] TOP_LANE = PW'(LANES - 1);

   initial begin
      assert (LANES >= 2 && (1 << PW) == LANES)
         else $error("dwbg_lane_ptr: LANES must be a power of two >= 2");
   end

   logic [PW-1:0] ptr_q;
   logic          bwd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         bwd_q <= 1'b0;
      end else if (load) begin
         bwd_q <= backward;
         ptr_q <= backward ? ~addr_lo : addr_lo;
      end else if (step) begin
         ptr_q <= bwd_q ? ptr_q - PW'(1) : ptr_q + PW'(1);
      end
   end

   assign ptr     = ptr_q;
   assign at_edge = bwd_q ? (ptr_q == '0) : (ptr_q == TOP_LANE);

   // after leaving the edge lane the pointer sits on the opposite edge
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && at_edge) |=> (ptr == ($past(bwd_q) ? TOP_LANE : '0))); // R2
endmodule

// File: rtl/dwbg_remain_cnt.sv
module dwbg_remain_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             is_last,
   output logic             is_zero
);
   initial begin
      assert (CNT_W >= 2) else $error("dwbg_remain_cnt: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
   end

   assign count   = cnt_q;
   assign is_last = (cnt_q == CNT_W'(1));
   assign is_zero = (cnt_q == '0);

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !is_zero); // R8
endmodule

// File: rtl/dwbg_lane_buf.sv
module dwbg_lane_buf #(
   parameter int LANES  = 8,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fill,
   input  logic [LANES*BYTE_W-1:0]   fill_data,
   input  logic                      wr_en,
   input  logic [$clog2(LANES)-1:0]  wr_lane,
   input  logic [BYTE_W-1:0]         wr_byte,
   input  logic [$clog2(LANES)-1:0]  rd_lane,
   output logic [BYTE_W-1:0]         rd_byte,
   output logic [LANES*BYTE_W-1:0]   q
);
   localparam int PW = $clog2(LANES);

   initial begin
      assert (BYTE_W >= 1 && LANES >= 2) else $error("dwbg_lane_buf: bad geometry");
   end

   logic [BYTE_W-1:0] lane_v [LANES];

   // lane 0 is the most significant byte of the doubleword
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int HI = (LANES - k) * BYTE_W - 1;
      logic [BYTE_W-1:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              byte_q <= '0;
         else if (fill)                           byte_q <= fill_data[HI -: BYTE_W];
         else if (wr_en && wr_lane == PW'(k))     byte_q <= wr_byte;
      end

      assign lane_v[k]       = byte_q;
      assign q[HI -: BYTE_W] = byte_q;
   end

   assign rd_byte = lane_v[rd_lane];

   AST_NO_FILL_AND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill && wr_en)); // R7
endmodule

// File: rtl/dwbg_byte_gate.sv
module dwbg_byte_gate
   import dwbg_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     start_dir,
   input  logic                     start_bwd,
   input  logic [$clog2(LANES)-1:0] start_lane,
   input  logic [CNT_W-1:0]         start_count,
   output logic                     fetch_req,
   input  logic                     fetch_ack,
   input  logic [LANES*BYTE_W-1:0]  fetch_data,
   output logic                     store_req,
   input  logic                     store_ack,
   output logic [LANES*BYTE_W-1:0]  store_data,
   output logic [LANES-1:0]         store_mask,
   input  logic                     dev_req,
   output logic                     dev_rdy,
   input  logic [BYTE_W-1:0]        dev_wbyte,
   output logic [BYTE_W-1:0]        dev_rbyte,
   output logic                     count_zero,
   output logic [CNT_W-1:0]         remaining
);
   localparam int PW = $clog2(LANES);
   localparam int DW = LANES * BYTE_W;

   initial begin
      assert ((1 << PW) == LANES && DW <= 1024)
         else $error("dwbg_byte_gate: LANES must be a power of two");
   end

   xfer_dir_e        dir_q;
   logic             act_q, buf_ok_q, st_pend_q, zero_q;
   logic [LANES-1:0] mask_q;

   logic [PW-1:0]    ptr;
   logic             at_edge, cnt_last, cnt_zero;
   logic             start_ok, xfer, fill;
   logic [DW-1:0]    buf_q;

   assign start_ok  = start && !act_q && !st_pend_q;
   assign dev_rdy   = act_q && ((dir_q == XFER_IN) ? !st_pend_q : buf_ok_q);
   assign xfer      = dev_req && dev_rdy;
   assign fetch_req = act_q && (dir_q == XFER_OUT) && !buf_ok_q;
   assign fill      = fetch_req && fetch_ack;

   dwbg_lane_ptr #(.LANES(LANES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .addr_lo(start_lane),
      .backward(start_bwd), .step(xfer), .ptr(ptr), .at_edge(at_edge));

   dwbg_remain_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .load_val(start_count),
      .dec(xfer), .count(remaining), .is_last(cnt_last), .is_zero(cnt_zero));

   dwbg_lane_buf #(.LANES(LANES), .BYTE_W(BYTE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .fill(fill), .fill_data(fetch_data),
      .wr_en(xfer && dir_q == XFER_IN), .wr_lane(ptr), .wr_byte(dev_wbyte),
      .rd_lane(ptr), .rd_byte(dev_rbyte), .q(buf_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         dir_q     <= XFER_OUT;
         buf_ok_q  <= 1'b0;
         st_pend_q <= 1'b0;
         zero_q    <= 1'b0;
         mask_q    <= '0;
      end else if (start_ok) begin
         act_q    <= (start_count != '0);
         dir_q    <= xfer_dir_e'(start_dir);
         buf_ok_q <= 1'b0;
         zero_q   <= (start_count == '0);
         mask_q   <= '0;
      end else begin
         if (fill) buf_ok_q <= 1'b1;
         if (xfer) begin
            if (cnt_last) begin
               act_q  <= 1'b0;
               zero_q <= 1'b1;
            end
            if (dir_q == XFER_OUT && at_edge) buf_ok_q <= 1'b0;
            if (dir_q == XFER_IN) begin
               mask_q[ptr] <= 1'b1;
               if (at_edge || cnt_last) st_pend_q <= 1'b1;
            end
         end
         if (st_pend_q && store_ack) begin
            st_pend_q <= 1'b0;
            mask_q    <= '0;
         end
      end
   end

   assign store_req  = st_pend_q;
   assign store_data = buf_q;
   assign store_mask = mask_q;
   assign count_zero = zero_q;

   AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> fetch_req); // R4
   AST_NOT_READY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !dev_rdy); // R5
   AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req && !store_ack) |=> (store_req && $stable(store_data) && $stable(store_mask))); // R10
   AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      count_zero |-> (!dev_rdy && !fetch_req && cnt_zero)); // R8
   AST_STORE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> (store_mask != '0)); // R9
   AST_LAST_BYTE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && remaining == CNT_W'(1)) |=> count_zero); // R8
endmodule

// File: tb/dwbg_byte_gate_test.sv
module dwbg_byte_gate_test;
   localparam int LANES = 8;
   localparam int BW    = 8;
   localparam int CW    = 16;
   localparam int DW    = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          start = 0, start_dir = 0, start_bwd = 0;
   logic [2:0]    start_lane = '0;
   logic [CW-1:0] start_count = '0;
   logic          fetch_req, fetch_ack = 0;
   logic [DW-1:0] fetch_data = '0;
   logic          store_req, store_ack = 0;
   logic [DW-1:0] store_data;
   logic [7:0]    store_mask;
   logic          dev_req = 0, dev_rdy;
   logic [7:0]    dev_wbyte = '0, dev_rbyte;
   logic          count_zero;
   logic [CW-1:0] remaining;

   dwbg_byte_gate #(.LANES(LANES), .BYTE_W(BW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
      .start_bwd(start_bwd), .start_lane(start_lane), .start_count(start_count),
      .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
      .store_req(store_req), .store_ack(store_ack), .store_data(store_data),
      .store_mask(store_mask), .dev_req(dev_req), .dev_rdy(dev_rdy),
      .dev_wbyte(dev_wbyte), .dev_rbyte(dev_rbyte), .count_zero(count_zero),
      .remaining(remaining));

   int tests = 0, fails = 0;
   logic [DW-1:0]   fq [$];
   logic [7:0]      bq [$];
   logic [DW+7:0]   sq [$];
   logic [7:0]      mdl [8];
   logic [7:0]      mmask = '0;
   logic [7:0]      exp_b;
   logic [DW+7:0]   exp_s;
   int  tb_ptr = 0;
   bit  tb_bwd = 0, cur_in = 0, done = 0;
   int  fetch_lat = 0, store_lat = 0, f_wait = 0, s_wait = 0, fetch_count = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] pack_mdl();
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[63-8*k -: 8] = mdl[k];
      return r;
   endfunction

   // storage fetch responder (also tracks the buffer model)
   initial forever begin
      @(posedge clk); #1;
      if (fetch_ack) fetch_ack = 0;
      else if (fetch_req && fq.size() != 0) begin
         if (f_wait >= fetch_lat) begin
            fetch_data = fq.pop_front();
            fetch_ack  = 1;
            f_wait     = 0;
            fetch_count++;
            for (int k = 0; k < 8; k++) mdl[k] = fetch_data[63-8*k -: 8];
         end else f_wait++;
      end
   end

   // storage store responder
   initial forever begin
      @(posedge clk); #1;
      if (store_ack) store_ack = 0;
      else if (store_req) begin
         if (s_wait >= store_lat) begin
            store_ack = 1;
            s_wait    = 0;
         end else s_wait++;
      end
   end

   // monitor: pops expected items as the design produces them
   initial forever begin
      @(negedge clk);
      if (rst_n && dev_req && dev_rdy && !cur_in) begin
         if (bq.size() == 0) check(0, "R4 unexpected byte", 64'(dev_rbyte), 64'h0);
         else begin
            exp_b = bq.pop_front();
            check(dev_rbyte == exp_b, "R2/R3/R4 outbound byte", 64'(dev_rbyte), 64'(exp_b));
         end
      end
      if (rst_n && store_req && store_ack) begin
         if (sq.size() == 0) check(0, "R6 unexpected store", store_data, 64'h0);
         else begin
            exp_s = sq.pop_front();
            check(store_data == exp_s[71:8], "R6/R7 store data", store_data, exp_s[71:8]);
            check(store_mask == exp_s[7:0], "R6/R9 store mask", 64'(store_mask), 64'(exp_s[7:0]));
         end
      end
   end

   task automatic dev_xfer(input logic [7:0] b);
      dev_req   = 1;
      dev_wbyte = b;
      do @(negedge clk); while (!dev_rdy);
      @(posedge clk); #1;
      dev_req = 0;
   endtask

   task automatic start_op(input bit din, input bit bwd, input int lane, input int cnt);
      cur_in = din; tb_bwd = bwd; tb_ptr = bwd ? 7 - lane : lane; mmask = '0;
      start = 1; start_dir = din; start_bwd = bwd;
      start_lane = 3'(lane); start_count = CW'(cnt);
      @(posedge clk); #1;
      start = 0;
   endtask

   task automatic out_op(input bit bwd, input int lane, input int n,
                         input logic [63:0] d0, input logic [63:0] d1, input bit poke);
      int p;
      logic [63:0] cur;
      fq.push_back(d0);
      p = bwd ? 7 - lane : lane;
      cur = d0;
      for (int i = 0; i < n; i++) begin
         bq.push_back(cur[63-8*p -: 8]);
         if (bwd ? (p == 0) : (p == 7)) begin
            cur = d1;
            if (i < n - 1) fq.push_back(d1);
         end
         p = bwd ? (p + 7) % 8 : (p + 1) % 8;
      end
      start_op(0, bwd, lane, n);
      if (poke) begin
         // R11: a start during the live transfer must be ignored
         start = 1; start_dir = 1; start_count = '0;
         @(posedge clk); #1;
         start = 0;
         @(negedge clk);
         check(count_zero == 0 && remaining == CW'(n), "R11 start ignored",
               {47'h0, count_zero, remaining}, 64'(n));
      end else begin
         dev_req = 1;
         @(negedge clk);
         check(fetch_req == 1 && dev_rdy == 0, "R5 held off during fetch",
               {fetch_req, dev_rdy}, 64'h2);
         check(remaining == CW'(n), "R8 count loaded", 64'(remaining), 64'(n));
      end
      @(posedge clk); #1;
      for (int i = 0; i < n; i++) dev_xfer(8'h00);
   endtask

   task automatic in_byte(input logic [7:0] b, input bit last);
      bit edge_l;
      mdl[tb_ptr] = b;
      mmask[tb_ptr] = 1'b1;
      edge_l = tb_bwd ? (tb_ptr == 0) : (tb_ptr == 7);
      if (edge_l || last) begin
         sq.push_back({pack_mdl(), mmask});
         mmask = '0;
      end
      tb_ptr = tb_bwd ? (tb_ptr + 7) % 8 : (tb_ptr + 1) % 8;
      dev_xfer(b);
   endtask

   task automatic drain_stores();
      while (sq.size() != 0) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic check_idle_zero(input string req);
      @(negedge clk);
      check(count_zero == 1 && remaining == 0, {req, " count reached zero"},
            {47'h0, count_zero, remaining}, 64'h10000);
      check(dev_rdy == 0 && fetch_req == 0, {req, " stopped"},
            {dev_rdy, fetch_req}, 64'h0);
      @(posedge clk); #1;
   endtask

   initial begin
      for (int k = 0; k < 8; k++) mdl[k] = '0;
      repeat (2) @(negedge clk);
      // R1: reset state
      check(fetch_req == 0 && store_req == 0, "R1 no requests in reset", {fetch_req, store_req}, 64'h0);
      check(dev_rdy == 0 && count_zero == 0, "R1 device side idle", {dev_rdy, count_zero}, 64'h0);
      check(remaining == 0 && store_data == 0, "R1 count and buffer clear", store_data, 64'h0);
      @(posedge clk); #1;
      rst_n = 1;
      @(posedge clk); #1;

      // R2/R4/R5/R8: forward outbound crossing a doubleword boundary
      fetch_lat = 3;
      out_op(0, 5, 5, 64'h0011223344556677, 64'h8899AABBCCDDEEFF, 0);
      check(fetch_count == 2, "R4 refetch after edge lane", 64'(fetch_count), 64'd2);
      check_idle_zero("R8");

      // R3: backward outbound, start lane 5 -> pointer 2, then 1, 0, 7
      out_op(1, 5, 4, 64'h1020304050607080, 64'hF1F2F3F4F5F6F7F8, 0);
      check(fetch_count == 4, "R3/R4 backward refetch", 64'(fetch_count), 64'd4);
      check_idle_zero("R3");

      // R6/R7/R10: forward inbound, lanes 6,7 then a full doubleword
      fetch_lat = 0;
      store_lat = 2;
      start_op(1, 0, 6, 10);
      in_byte(8'hA0, 0);
      in_byte(8'hA1, 0);
      @(negedge clk);
      check(store_req == 1 && dev_rdy == 0, "R10 held off while store pending",
            {store_req, dev_rdy}, 64'h2);
      @(posedge clk); #1;
      for (int i = 2; i < 10; i++) in_byte(8'(8'hA0 + i), i == 9);
      drain_stores();
      check_idle_zero("R6");

      // R9/R7: backward inbound partial, start lane 0 -> lanes 7,6,5
      start_op(1, 1, 0, 3);
      in_byte(8'hC7, 0);
      in_byte(8'hC6, 0);
      in_byte(8'hC5, 1);
      drain_stores();
      check_idle_zero("R9");

      // R7/R9: forward inbound partial in mid buffer, lanes 3,4
      start_op(1, 0, 3, 2);
      in_byte(8'h5A, 0);
      in_byte(8'h5B, 1);
      drain_stores();

      // R11: start pulse while outbound is active
      out_op(0, 0, 2, 64'hDEADBEEFCAFEF00D, 64'h0, 1);
      check_idle_zero("R11");

      // R12: zero-count start
      start_op(1, 0, 0, 0);
      @(negedge clk);
      check(count_zero == 1, "R12 zero flag at once", 64'(count_zero), 64'h1);
      @(negedge clk);
      check(fetch_req == 0 && store_req == 0 && dev_rdy == 0, "R12 no activity",
            {fetch_req, store_req, dev_rdy}, 64'h0);
      start_op(0, 0, 0, 0);
      @(negedge clk);
      check(fetch_req == 0 && count_zero == 1, "R12 outbound zero count",
            {fetch_req, count_zero}, 64'h1);

      check(bq.size() == 0 && sq.size() == 0, "R4/R6 all expected items seen",
            64'(bq.size() + sq.size()), 64'h0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule